// File: doc/BRIEF.md
# Parallel SDI Scrambler with NRZI Encoder

This block takes one parallel character per clock and runs it through a self-synchronizing scrambler with polynomial x^9 + x^4 + 1, then through an NRZ-to-NRZI converter. The character runs at one tenth of the serial bit rate. Every bit position of the character is handled in the same clock. Scrambler history and the NRZI level carry from one character to the next, so serializing the output with bit 0 first gives the same stream as a bit-serial encoder. Scrambling raises the transition density and lowers the DC content of the line. The NRZI stage also makes the stream insensitive to a polarity swap on the link.

A bypass flag is registered with each character. A flagged character passes around both stages unchanged, which gives raw output for diagnostics or for streams that must not be coded. Bypass and coded characters share the same two-register latency. The encoder state does not move during bypass characters, so coding resumes exactly where it paused.

Top module: `sdi_scrambler_nrzi`

## Requirements
- R1: With bypass low, the scrambled bit is s[n] = d[n] XOR s[n-4] XOR s[n-9]. Here n counts serial bits with character bit 0 sent first, and the history is made of earlier scrambled bits, including those of earlier characters.
- R2: With bypass low, the output bit is y[n] = s[n] XOR y[n-1]. The level of the last bit (bit CHAR_W-1) of one character is y[n-1] for bit 0 of the next coded character.
- R3: A character presented with bypass high appears on the output exactly as presented.
- R4: A bypass character leaves the scrambler history and the NRZI level unchanged. The next coded character is encoded as if the bypass characters had never been sent.
- R5: A character sampled at clock edge k appears on the output after edge k+1, whether bypass is high or low.
- R6: Synchronous reset clears the output, the scrambler history and the NRZI level to zero. After reset, the first coded character sees an all-zero history.
- R7: Bypass is sampled with each character, so coded and bypass characters may alternate on consecutive clocks without loss or stall.
- R8: Over a long run of mixed characters, the output equals a bit-serial model of the scrambler followed by the NRZI stage, applied to the concatenation of the coded characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | CHAR_W (10) | Input character, bit 0 sent first on the line |
| bypass | input | 1 | High: send this character uncoded |
| dout | output | CHAR_W (10) | Registered coded or raw character |

## Verification
The bench builds the block with its default ten-bit character and taps at 4 and 9. At this width the long tap reaches back across the character boundary for nine of the ten bit positions, and the short tap does so for four of them. Both carry paths between characters are therefore exercised by every coded word. Impulse, all-ones, random and alternating-bypass runs are compared on every clock against a behavioural bit-serial model. A mid-run reset confirms that the history restarts from zero.

// File: rtl/scr_pkg.sv
package scr_pkg;
   localparam int unsigned SCR_CHAR_W    = 10;
   localparam int unsigned SCR_TAP_SHORT = 4;
   localparam int unsigned SCR_TAP_LONG  = 9;
endpackage

// File: rtl/scr_in_reg.sv
module scr_in_reg #(
   parameter int unsigned CHAR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CHAR_W-1:0] din,
   input  logic              bypass,
   output logic [CHAR_W-1:0] char_q,
   output logic              byp_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         char_q <= '0;
         byp_q  <= 1'b0;
      end else begin
         char_q <= din;
         byp_q  <= bypass;
      end
   end
endmodule

// File: rtl/scr_lfsr_par.sv
module scr_lfsr_par #(
   parameter int unsigned CHAR_W    = 10,
   parameter int unsigned TAP_SHORT = 4,
   parameter int unsigned TAP_LONG  = 9
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic [CHAR_W-1:0]   d_i,
   output logic [CHAR_W-1:0]   s_o,
   output logic [TAP_LONG-1:0] hist_o
);
   localparam int unsigned EXT_W = TAP_LONG + CHAR_W;

   // hist_q[0] is the most recent scrambled bit, hist_q[TAP_LONG-1] the oldest
   logic [TAP_LONG-1:0] hist_q;
   logic [TAP_LONG-1:0] hist_d;

   always_comb begin : p_unroll
      logic [EXT_W-1:0] ext;
      ext = '0;
      for (int m = 0; m < int'(TAP_LONG); m++)
         ext[m] = hist_q[int'(TAP_LONG) - 1 - m];
      for (int i = 0; i < int'(CHAR_W); i++)
         ext[int'(TAP_LONG) + i] = d_i[i]
                                 ^ ext[int'(TAP_LONG) + i - int'(TAP_SHORT)]
                                 ^ ext[i];
      s_o = ext[TAP_LONG +: CHAR_W];
      for (int j = 0; j < int'(TAP_LONG); j++)
         hist_d[j] = ext[int'(EXT_W) - 1 - j];
   end

   always_ff @(posedge clk) begin
      if (rst)       hist_q <= '0;
      else if (adv)  hist_q <= hist_d;
   end

   assign hist_o = hist_q;

   AST_SCR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(hist_q)); // R4
endmodule

// File: rtl/scr_nrzi_par.sv
module scr_nrzi_par #(
   parameter int unsigned CHAR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic [CHAR_W-1:0] s_i,
   output logic [CHAR_W-1:0] y_o,
   output logic              lvl_o
);
   logic lvl_q;

   always_comb begin : p_chain
      logic run;
      run = lvl_q;
      for (int i = 0; i < int'(CHAR_W); i++) begin
         run    = run ^ s_i[i];
         y_o[i] = run;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      lvl_q <= 1'b0;
      else if (adv) lvl_q <= y_o[CHAR_W-1];
   end

   assign lvl_o = lvl_q;

   AST_NRZI_HOLD: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(lvl_q)); // R4
endmodule

// File: rtl/sdi_scrambler_nrzi.sv
module sdi_scrambler_nrzi #(
   parameter int unsigned CHAR_W    = scr_pkg::SCR_CHAR_W,
   parameter int unsigned TAP_SHORT = scr_pkg::SCR_TAP_SHORT,
   parameter int unsigned TAP_LONG  = scr_pkg::SCR_TAP_LONG
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CHAR_W-1:0] din,
   input  logic              bypass,
   output logic [CHAR_W-1:0] dout
);
   generate
      if (CHAR_W < 2) begin : g_bad_width
         $error("CHAR_W must be at least 2");
      end
      if (TAP_SHORT < 1 || TAP_SHORT >= TAP_LONG) begin : g_bad_taps
         $error("taps must satisfy 1 <= TAP_SHORT < TAP_LONG");
      end
   endgenerate

   logic [CHAR_W-1:0]   char_q;
   logic                byp_q;
   logic                adv;
   logic [CHAR_W-1:0]   scr_w;
   logic [CHAR_W-1:0]   enc_w;
   logic [TAP_LONG-1:0] hist;
   logic                lvl;
   logic [CHAR_W-1:0]   dout_q;

   scr_in_reg #(.CHAR_W(CHAR_W)) u_in (
      .clk(clk), .rst(rst), .din(din), .bypass(bypass),
      .char_q(char_q), .byp_q(byp_q)
   );

   assign adv = ~byp_q;

   scr_lfsr_par #(.CHAR_W(CHAR_W), .TAP_SHORT(TAP_SHORT), .TAP_LONG(TAP_LONG)) u_scr (
      .clk(clk), .rst(rst), .adv(adv), .d_i(char_q),
      .s_o(scr_w), .hist_o(hist)
   );

   scr_nrzi_par #(.CHAR_W(CHAR_W)) u_nrzi (
      .clk(clk), .rst(rst), .adv(adv), .s_i(scr_w),
      .y_o(enc_w), .lvl_o(lvl)
   );

   always_ff @(posedge clk) begin
      if (rst)        dout_q <= '0;
      else if (byp_q) dout_q <= char_q;
      else            dout_q <= enc_w;
   end

   assign dout = dout_q;

   // cycles since reset, saturating at two, to bound the $past window
   logic [1:0] warm_q;
   always_ff @(posedge clk) begin
      if (rst)                 warm_q <= 2'd0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
   end

   AST_BYP_PASS: assert property (@(posedge clk) disable iff (rst)
      byp_q |=> dout == $past(char_q)); // R3
   AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (warm_q == 2'd2 && $past(bypass, 2)) |-> dout == $past(din, 2)); // R5
   AST_NRZI_LINK: assert property (@(posedge clk) disable iff (rst)
      adv |=> lvl == dout[CHAR_W-1]); // R2
   AST_SCR_LINK: assert property (@(posedge clk) disable iff (rst)
      adv |=> hist[0] == (dout[CHAR_W-1] ^ dout[CHAR_W-2])); // R1
endmodule

// File: tb/sdi_scrambler_nrzi_tb.sv
`timescale 1ns/1ps
module sdi_scrambler_nrzi_tb;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] din = '0;
   logic         bypass = 1'b0;
   logic [W-1:0] dout;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string tag = "R6";

   bit           sh[$];
   bit           ylvl;
   logic [W-1:0] expq[$];

   always #2.5 clk = ~clk;

   sdi_scrambler_nrzi u_dut (
      .clk(clk), .rst(rst), .din(din), .bypass(bypass), .dout(dout)
   );

   task automatic model_reset();
      sh.delete();
      for (int k = 0; k < 9; k++) sh.push_back(1'b0);
      ylvl = 1'b0;
   endtask

   // behavioural bit-serial reference: scrambler then NRZI, bit 0 first
   task automatic model_word(input logic [W-1:0] d, input logic b, output logic [W-1:0] e);
      if (b) begin
         e = d;
      end else begin
         for (int i = 0; i < W; i++) begin
            bit s;
            s = d[i] ^ sh[sh.size()-4] ^ sh[sh.size()-9];
            sh.push_back(s);
            void'(sh.pop_front());
            ylvl = ylvl ^ s;
            e[i] = ylvl;
         end
      end
   endtask

   task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic step(input logic [W-1:0] d, input logic b);
      logic [W-1:0] e;
      din = d;
      bypass = b;
      model_word(d, b, e);
      expq.push_back(e);
      @(negedge clk);
      check(dout, expq.pop_front());
   endtask

   task automatic do_reset();
      rst = 1'b1;
      din = '0;
      bypass = 1'b0;
      repeat (3) @(negedge clk);
      tag = "R6 reset clears output";
      check(dout, '0);
      rst = 1'b0;
      model_reset();
      expq.delete();
      expq.push_back('0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      @(negedge clk);
      do_reset();

      tag = "R1 zero input keeps zero";
      repeat (4) step('0, 1'b0);

      tag = "R1 R8 impulse through history";
      step(10'h001, 1'b0);
      repeat (6) step('0, 1'b0);

      tag = "R2 all ones";
      repeat (6) step('1, 1'b0);

      tag = "R8 random coded";
      repeat (200) step(W'($urandom), 1'b0);

      tag = "R3 R5 bypass raw";
      step(10'h2A5, 1'b1);
      step(10'h15A, 1'b1);
      step(10'h3FF, 1'b1);
      step(10'h000, 1'b1);

      tag = "R4 resume after bypass";
      repeat (8) step(W'($urandom), 1'b0);

      tag = "R7 alternating bypass";
      for (int k = 0; k < 60; k++) step(W'($urandom), k[0]);

      tag = "R4 long bypass run";
      repeat (20) step(W'($urandom), 1'b1);
      repeat (10) step(W'($urandom), 1'b0);

      tag = "R8 mixed random";
      repeat (400) step(W'($urandom), ($urandom % 4) == 0);

      do_reset();
      tag = "R6 fresh history after reset";
      step(10'h001, 1'b0);
      repeat (3) step(10'h3FC, 1'b0);
      step('0, 1'b0);
      step('0, 1'b0);

      finish_run();
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL R7 watchdog: actual=hung expected=complete");
         finish_run();
      end
   end
endmodule